// File: doc/BRIEF.md
# Lockable Window Base Register and Claim Decoder

This block holds two configuration registers and uses one of them to claim memory requests. The first register is a 16-bit subsystem identity. It resets to zero, and it accepts a single write after each reset. The second register is a 32-bit window base register. Its upper field places a naturally aligned 4 KB window in a 32-bit address space, and bit 0 switches memory decoding of that window on or off. A secure-launch lock input freezes the base field and the enable bit for as long as the lock is held. The block does not latch the lock. It samples the lock on each write cycle.

A memory request is an address with a valid strobe. The block claims the request one cycle later when decoding is enabled and address bits 31:12 equal the stored base. A separate sideband request path reaches the registers behind the window. The block always honours sideband requests, whatever the state of the enable bit.

The configuration port uses byte offsets and byte enables. The identity register lives in lanes 3:2 of the dword at offset 0x2C, which is byte offset 0x2E. The base register is the dword at offset 0x50. Reads return data combinationally from the offset presented.

Top module: `cfgwin_decoder`

## Requirements
- R1: After reset the identity reads 0x0000, the base register reads 0x00000000, and both claim_o and sb_ack_o are 0.
- R2: The first write to offset 0x2C after reset with either of byte lanes 2 or 3 enabled updates the enabled lanes of the identity. The identity occupies rdata[31:16] at offset 0x2C.
- R3: Once the identity has taken its write, every later identity write is ignored until the next reset. After a reset the identity accepts one write again.
- R4: When unlocked, a write to offset 0x50 updates only the implemented bits in the enabled lanes. Bits 31:12 form the base and bit 0 is the enable.
- R5: Bits 11:1 of the base register always read zero, whatever data was written.
- R6: While lock_i is 1, writes to offset 0x50 leave the base and the enable unchanged.
- R7: With enable set, a request with mem_valid_i=1 and mem_addr_i[31:12] equal to the base raises claim_o on the next cycle. Any other request leaves claim_o at 0 on the next cycle.
- R8: With enable clear, claim_o stays 0 for every request.
- R9: A sideband request on sb_valid_i is acknowledged on sb_ack_o one cycle later, with the enable set or clear.
- R10: Reads of unimplemented offsets return zero, and writes to them change no register.
- R11: An identity write whose enabled lanes are only 1:0 does not count as the single write, and it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte offset (bits 1:0 ignored) |
| cfg_be_i | input | 4 | Byte lane enables for writes |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| lock_i | input | 1 | Secure-launch lock, freezes the base register |
| mem_valid_i | input | 1 | Memory request valid |
| mem_addr_i | input | 32 | Memory request address |
| claim_o | output | 1 | Request claimed (one cycle after the request) |
| sb_valid_i | input | 1 | Sideband access to the window registers |
| sb_ack_o | output | 1 | Sideband access honoured (one cycle later) |

## Verification
Decoding is tried with the lowest and highest bytes of the window, and with the addresses just below and just above it. This separates an exact 20-bit compare from a compare that is off by one or that masks too few bits. A matching address with the strobe low, and an address that differs only in bit 31, show whether the strobe and the top bit take part in the compare. The identity register is written with lanes 1:0 only, then with lanes 3:2, then again, and again after a second reset. This separates "any enabled lane counts" from "any write counts" and from a write-once flag that never re-arms. Locked writes, unimplemented offsets and a single-lane write to the enable bit show that each path changes only the state it owns.

// File: rtl/cfgwin_pkg.sv
package cfgwin_pkg;
   localparam int unsigned CFG_OFS_W   = 8;
   localparam int unsigned CFG_DATA_W  = 32;
   localparam logic [CFG_OFS_W-1:0] ID_DW_OFS  = 8'h2C;
   localparam logic [CFG_OFS_W-1:0] BAR_DW_OFS = 8'h50;
   localparam int unsigned ID_LANE_LO  = 2;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_ID   = 2'd1,
      SEL_BAR  = 2'd2
   } cfg_sel_e;
endpackage

// File: rtl/cfgwin_once_reg.sv
module cfgwin_once_reg #(
   parameter int unsigned W = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           we,
   input  logic [W/8-1:0] be,
   input  logic [W-1:0]   wdata,
   output logic [W-1:0]   q
);
   localparam int unsigned LANES = W / 8;

   if ((W % 8) != 0 || W == 0) begin : g_bad_w
      $error("cfgwin_once_reg: W must be a non-zero multiple of 8");
   end

   logic used_q;
   logic take;

   assign take = we && (|be) && !used_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    used_q <= 1'b0;
      else if (take) used_q <= 1'b1;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)              q[8*l +: 8] <= '0;
         else if (take && be[l])  q[8*l +: 8] <= wdata[8*l +: 8];
      end
   end

   // R3: after the one accepted write the value never moves
   p_once_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      used_q |=> $stable(q));
endmodule

// File: rtl/cfgwin_lock_bar.sv
module cfgwin_lock_bar #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_BITS = 12
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic                       lock,
   input  logic [ADDR_W/8-1:0]        be,
   input  logic [ADDR_W-1:0]          wdata,
   output logic [ADDR_W-1:0]          image,
   output logic [ADDR_W-WIN_BITS-1:0] base,
   output logic                       en
);
   localparam int unsigned LANES = ADDR_W / 8;
   localparam logic [ADDR_W-1:0] IMPL_MASK =
      ({ADDR_W{1'b1}} << WIN_BITS) | {{(ADDR_W-1){1'b0}}, 1'b1};

   if (WIN_BITS < 2 || WIN_BITS >= ADDR_W || (ADDR_W % 8) != 0) begin : g_bad_p
      $error("cfgwin_lock_bar: unsupported ADDR_W/WIN_BITS combination");
   end

   logic [ADDR_W-1:0] img_q;
   logic              wr_ok;

   assign wr_ok = we && !lock;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)              img_q[8*l +: 8] <= '0;
         else if (wr_ok && be[l]) img_q[8*l +: 8] <= wdata[8*l +: 8] & IMPL_MASK[8*l +: 8];
      end
   end

   assign image = img_q;
   assign base  = img_q[ADDR_W-1:WIN_BITS];
   assign en    = img_q[0];

   // R6: a locked write leaves the whole register untouched
   p_lock_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (we && lock) |=> $stable(img_q));
   // R5: reserved bits never hold a one
   p_rsvd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (img_q[WIN_BITS-1:1] == '0));
endmodule

// File: rtl/cfgwin_claim.sv
module cfgwin_claim #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_BITS = 12,
   parameter bit          REG_OUT  = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       mem_valid,
   input  logic [ADDR_W-1:0]          mem_addr,
   input  logic [ADDR_W-WIN_BITS-1:0] base,
   input  logic                       en,
   input  logic                       sb_valid,
   output logic                       claim,
   output logic                       sb_ack
);
   logic hit;

   assign hit = mem_valid && en && (mem_addr[ADDR_W-1:WIN_BITS] == base);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            claim  <= 1'b0;
            sb_ack <= 1'b0;
         end else begin
            claim  <= hit;
            sb_ack <= sb_valid;
         end
      end

      // R8: a disabled window never produces a claim on the next cycle
      p_no_claim_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !claim);
      // R9: sideband requests are acknowledged independent of enable
      p_sb_honour_r9: assert property (@(posedge clk) disable iff (!rst_n)
         sb_valid |=> sb_ack);
      // R7: no claim without a valid request the cycle before
      p_claim_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !mem_valid |=> !claim);
   end else begin : g_comb
      assign claim  = hit;
      assign sb_ack = sb_valid;
   end
endmodule

// File: rtl/cfgwin_decoder.sv
module cfgwin_decoder
   import cfgwin_pkg::*;
#(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned WIN_BITS = 12,
   parameter int unsigned ID_W     = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_wr_i,
   input  logic [CFG_OFS_W-1:0]  cfg_addr_i,
   input  logic [3:0]            cfg_be_i,
   input  logic [CFG_DATA_W-1:0] cfg_wdata_i,
   output logic [CFG_DATA_W-1:0] cfg_rdata_o,
   input  logic                  lock_i,
   input  logic                  mem_valid_i,
   input  logic [ADDR_W-1:0]     mem_addr_i,
   output logic                  claim_o,
   input  logic                  sb_valid_i,
   output logic                  sb_ack_o
);
   localparam int unsigned ID_LANES = ID_W / 8;
   localparam int unsigned ID_LSB   = 8 * ID_LANE_LO;

   if (ADDR_W != CFG_DATA_W) begin : g_bad_aw
      $error("cfgwin_decoder: ADDR_W must match the configuration data width");
   end
   if (ID_LSB + ID_W > CFG_DATA_W) begin : g_bad_id
      $error("cfgwin_decoder: identity field does not fit its dword");
   end

   cfg_sel_e sel;
   always_comb begin
      unique case (cfg_addr_i[CFG_OFS_W-1:2])
         ID_DW_OFS[CFG_OFS_W-1:2]:  sel = SEL_ID;
         BAR_DW_OFS[CFG_OFS_W-1:2]: sel = SEL_BAR;
         default:                   sel = SEL_NONE;
      endcase
   end

   logic [ID_W-1:0]            id_q;
   logic [ADDR_W-1:0]          bar_img;
   logic [ADDR_W-WIN_BITS-1:0] bar_base;
   logic                       bar_en;

   cfgwin_once_reg #(.W(ID_W)) u_id (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_wr_i && (sel == SEL_ID)),
      .be    (cfg_be_i[ID_LANE_LO +: ID_LANES]),
      .wdata (cfg_wdata_i[ID_LSB +: ID_W]),
      .q     (id_q)
   );

   cfgwin_lock_bar #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_bar (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_wr_i && (sel == SEL_BAR)),
      .lock  (lock_i),
      .be    (cfg_be_i),
      .wdata (cfg_wdata_i),
      .image (bar_img),
      .base  (bar_base),
      .en    (bar_en)
   );

   cfgwin_claim #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .REG_OUT(1'b1)) u_claim (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_valid (mem_valid_i),
      .mem_addr  (mem_addr_i),
      .base      (bar_base),
      .en        (bar_en),
      .sb_valid  (sb_valid_i),
      .claim     (claim_o),
      .sb_ack    (sb_ack_o)
   );

   always_comb begin
      cfg_rdata_o = '0;
      case (sel)
         SEL_ID:  cfg_rdata_o[ID_LSB +: ID_W] = id_q;
         SEL_BAR: cfg_rdata_o = bar_img;
         default: cfg_rdata_o = '0;
      endcase
   end

   // R10: unimplemented offsets read back as zero
   p_unimpl_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (cfg_rdata_o == '0));
endmodule

// File: tb/cfgwin_decoder_tb_top.sv
module cfgwin_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [3:0]  cfg_be = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        lock = 1'b0;
   logic        mem_valid = 1'b0;
   logic [31:0] mem_addr = '0;
   logic        claim;
   logic        sb_valid = 1'b0;
   logic        sb_ack;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   cfgwin_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_addr_i(cfg_addr),
      .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
      .lock_i(lock), .mem_valid_i(mem_valid), .mem_addr_i(mem_addr),
      .claim_o(claim), .sb_valid_i(sb_valid), .sb_ack_o(sb_ack)
   );

   // {address, valid, expected claim} with base 0x12345 and enable set (R7)
   localparam logic [33:0] VEC [8] = '{
      {32'h1234_5000, 1'b1, 1'b1},
      {32'h1234_5FFF, 1'b1, 1'b1},
      {32'h1234_57A4, 1'b1, 1'b1},
      {32'h1234_4FFF, 1'b1, 1'b0},
      {32'h1234_6000, 1'b1, 1'b0},
      {32'h1234_5800, 1'b0, 1'b0},
      {32'h9234_5000, 1'b1, 1'b0},
      {32'h0000_0000, 1'b1, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic mem_req(input logic [31:0] a, input logic v, output logic c);
      @(negedge clk);
      mem_valid = v; mem_addr = a;
      @(posedge clk);
      #1 c = claim;
      mem_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] rd;
      logic        c;
      do_reset();

      // R1 reset state
      cfg_read(8'h2C, rd); check("R1 identity", rd, 32'h0);
      cfg_read(8'h50, rd); check("R1 base reg", rd, 32'h0);
      check("R1 claim", {31'h0, claim}, 32'h0);
      check("R1 sb_ack", {31'h0, sb_ack}, 32'h0);

      // R11: lanes 1:0 only do not consume the single write
      cfg_write(8'h2C, 32'hBEEF_BEEF, 4'b0011);
      cfg_read(8'h2C, rd); check("R11 low lanes ignored", rd, 32'h0);
      // R2: first real write
      cfg_write(8'h2E, 32'hABCD_0000, 4'b1100);
      cfg_read(8'h2C, rd); check("R2 first write", rd, 32'hABCD_0000);
      // R3: later write ignored
      cfg_write(8'h2C, 32'h5555_0000, 4'b0100);
      cfg_read(8'h2C, rd); check("R3 second write", rd, 32'hABCD_0000);

      // R10: unimplemented offset
      cfg_write(8'h40, 32'hFFFF_FFFF, 4'hF);
      cfg_read(8'h40, rd); check("R10 unimpl read", rd, 32'h0);
      cfg_read(8'h50, rd); check("R10 base untouched", rd, 32'h0);

      // R4 / R5: base write, reserved bits dropped
      cfg_write(8'h50, 32'h1234_5FFF, 4'hF);
      cfg_read(8'h50, rd); check("R4 R5 base write", rd, 32'h1234_5001);

      // R7 table walk
      foreach (VEC[i]) begin
         mem_req(VEC[i][33:2], VEC[i][1], c);
         check($sformatf("R7 vector %0d", i), {31'h0, c}, {31'h0, VEC[i][0]});
      end

      // R6: locked writes ignored
      lock = 1'b1;
      cfg_write(8'h50, 32'hAAAA_A000, 4'hF);
      cfg_write(8'h50, 32'h0, 4'b0001);
      cfg_read(8'h50, rd); check("R6 locked", rd, 32'h1234_5001);
      lock = 1'b0;

      // R8: enable clear stops claims
      cfg_write(8'h50, 32'h1234_5000, 4'b0001);
      cfg_read(8'h50, rd); check("R4 enable lane only", rd, 32'h1234_5000);
      mem_req(32'h1234_5010, 1'b1, c);
      check("R8 disabled claim", {31'h0, c}, 32'h0);

      // R9: sideband honoured with enable clear
      @(negedge clk); sb_valid = 1'b1;
      @(posedge clk); #1 check("R9 sb ack disabled", {31'h0, sb_ack}, 32'h1);
      @(negedge clk); sb_valid = 1'b0;
      @(posedge clk); #1 check("R9 sb ack drops", {31'h0, sb_ack}, 32'h0);

      // R4: single upper lane updates only its bits
      cfg_write(8'h50, 32'h7700_0001, 4'b1001);
      cfg_read(8'h50, rd); check("R4 partial lanes", rd, 32'h7734_5001);
      mem_req(32'h7734_5ABC, 1'b1, c);
      check("R7 moved window", {31'h0, c}, 32'h1);
      @(negedge clk); sb_valid = 1'b1;
      @(posedge clk); #1 check("R9 sb ack enabled", {31'h0, sb_ack}, 32'h1);
      @(negedge clk); sb_valid = 1'b0;

      // R3: reset re-arms the identity write
      do_reset();
      cfg_read(8'h50, rd); check("R1 base after reset", rd, 32'h0);
      cfg_write(8'h2C, 32'h1111_0000, 4'b1000);
      cfg_read(8'h2C, rd); check("R3 rearmed after reset", rd, 32'h1100_0000);
      cfg_write(8'h2C, 32'h2222_0000, 4'b1100);
      cfg_read(8'h2C, rd); check("R3 frozen again", rd, 32'h1100_0000);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule